// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block sits between a processor load/store port and a block-oriented memory. It holds 64 lines of 16 bytes, each line tagged with the upper address bits and carrying a valid bit and a dirty bit. Stores that hit change only the cached copy and mark the line dirty, so main memory sees traffic only when a line is filled or a modified line is evicted.

On a miss whose target line is modified, the old contents are first moved into a single-block holding register. The read burst for the new block is then issued at once, and the parked block is written to memory only after the fill is complete. The read burst starts at the requested word and wraps around the block. The processor is released on that first beat, while the remaining words are still arriving. A store miss allocates the line: its data is merged into the arriving block, and the line ends up dirty.

A request is presented with `cpu_req` and completes in the cycle where `cpu_stall` is low while `cpu_req` is high. The requester drops or replaces the request after that cycle.

Top module: `wb_dm_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any line is a miss that issues a memory read.
- R2: The address splits into tag bits [31:10], line index bits [9:4] and word select bits [3:2]. A refill request carries the word-aligned address of the requested word.
- R3: A read hits when the indexed line is valid and its tag matches. It completes in the first cycle after the request is taken, with the stored word and no memory traffic.
- R4: A write hit replaces the addressed word in the line, marks the line dirty and causes no memory read or write.
- R5: A miss on a clean or invalid line issues one read burst and no write beats.
- R6: A miss on a dirty line copies that line into the victim buffer and issues the refill read first. No write beat is offered until the last refill beat has been taken.
- R7: Refill beats arrive in wrap order, starting at the requested word and stepping by one word modulo four. The requester is released on the first beat and, for a read, receives that beat's data.
- R8: A write miss fills the line with the write merged in and leaves it dirty, so a later eviction writes the merged word back.
- R9: A write-back sends four beats to the victim block, word 0 to word 3 in order. Each beat's address and data are held while `mem_wr_ready` is low.
- R10: A miss that arrives while the victim buffer still holds data waits until the buffer has drained. A re-fetch of the evicted block therefore returns the written-back data.
- R11: Directly after reset, with no request present, `cpu_stall`, `mem_rd_req` and `mem_wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | High while a present request is not yet complete |
| cpu_rdata | output | 32 | Load data, valid when the request completes |
| mem_rd_req | output | 1 | One-cycle pulse starting a four-beat read burst |
| mem_rd_addr | output | 32 | Address of the critical word of the burst |
| mem_rd_valid | input | 1 | Read beat present |
| mem_rd_data | input | 32 | Read beat data |
| mem_wr_valid | output | 1 | Write-back beat offered |
| mem_wr_addr | output | 32 | Word address of the offered beat |
| mem_wr_data | output | 32 | Data of the offered beat |
| mem_wr_ready | input | 1 | Memory takes the offered beat this cycle |

## Verification
The assertions assume that the memory delivers read beats only during a refill, and only after the read request has been issued. They also assume that the requester presents only word-aligned addresses. The bench's memory model answers only after it has observed `mem_rd_req`. It then sends exactly four consecutive beats in wrap order and toggles `mem_wr_ready` every cycle, so the hold rule for write-back beats gets exercised. The requester drives aligned addresses on the falling edge and removes each request as soon as it completes. Back-to-back requests are used so that a miss lands while a victim is still draining.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 6;
  localparam int OFF_W  = 4;
  localparam int WORD_W = 32;
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BYTE_W;
  localparam int WORDS  = 1 << WSEL_W;
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int LINE_W = WORDS * WORD_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_EVICT_COPY,
    ST_REFILL,
    ST_WRITEBACK
  } cst_e;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[BYTE_W +: WSEL_W];
  endfunction

  // beat n of a burst that starts at word crit
  function automatic logic [WSEL_W-1:0] wrap_word(input logic [WSEL_W-1:0] crit,
                                                   input logic [WSEL_W-1:0] beat);
    return crit + beat;
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [TAG_W-1:0] t,
                                                   input logic [IDX_W-1:0] i,
                                                   input logic [WSEL_W-1:0] w);
    return {t, i, w, {BYTE_W{1'b0}}};
  endfunction
endpackage

// File: rtl/cwb_line_store.sv
module cwb_line_store
  import cwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line,
  input  logic              hit_wr_en,
  input  logic [WSEL_W-1:0] hit_word,
  input  logic [WORD_W-1:0] hit_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              fill_dirty
);
  logic [LINES-1:0]  valid_q;
  logic [LINES-1:0]  dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_line  = data_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= fill_dirty;
    end else if (hit_wr_en) begin
      dirty_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx]  <= fill_tag;
      data_q[idx] <= fill_line;
    end else if (hit_wr_en) begin
      data_q[idx][hit_word*WORD_W +: WORD_W] <= hit_data;
    end
  end

  // R4
  hit_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wr_en |=> dirty_q[$past(idx)]);

  // R8
  fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(idx)] && (dirty_q[$past(idx)] == $past(fill_dirty)));
endmodule

// File: rtl/cwb_victim_buf.sv
module cwb_victim_buf
  import cwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [TAG_W-1:0]  load_tag,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [LINE_W-1:0] load_line,
  input  logic              drain_go,
  output logic              full,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LINE_W-1:0] line_q;
  logic [WSEL_W-1:0] beat_q;
  logic              full_q;
  logic              beat_taken;

  assign full         = full_q;
  assign mem_wr_valid = full_q && drain_go;
  assign mem_wr_addr  = word_addr(tag_q, idx_q, beat_q);
  assign mem_wr_data  = line_q[beat_q*WORD_W +: WORD_W];
  assign beat_taken   = mem_wr_valid && mem_wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      beat_q <= '0;
    end else if (load_en) begin
      full_q <= 1'b1;
      beat_q <= '0;
    end else if (beat_taken) begin
      beat_q <= beat_q + 1'b1;
      if (beat_q == LAST_BEAT) full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      tag_q  <= load_tag;
      idx_q  <= load_idx;
      line_q <= load_line;
    end
  end

  // R10
  vb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> !full_q);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [LINE_W-1:0] lk_line,
  output logic              hit_wr_en,
  output logic [WSEL_W-1:0] hit_word,
  output logic [WORD_W-1:0] hit_data,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic [LINE_W-1:0] fill_line,
  output logic              fill_dirty,
  input  logic              vb_full,
  output logic              vb_load,
  output logic              drain_go,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              refilling
);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  cst_e              state_q, state_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [WORD_W-1:0] req_wdata_q;
  logic [WSEL_W-1:0] beat_q;
  logic [LINE_W-1:0] fill_q, fill_next;
  logic              rd_issued_q;
  logic              served_q;

  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_word;
  logic              lookup_hit;
  logic              crit_beat;
  logic              last_beat;
  logic              done;
  logic [WORD_W-1:0] beat_word;

  always_comb begin
    req_tag    = tag_of(req_addr_q);
    req_word   = word_of(req_addr_q);
    lk_idx     = idx_of(req_addr_q);
    lookup_hit = lk_valid && (lk_tag == req_tag);
    refilling  = (state_q == ST_REFILL);
    crit_beat  = refilling && mem_rd_valid && (beat_q == '0);
    last_beat  = refilling && mem_rd_valid && (beat_q == LAST_BEAT);
    beat_word  = (crit_beat && req_we_q) ? req_wdata_q : mem_rd_data;
    fill_next  = fill_q;
    if (refilling && mem_rd_valid)
      fill_next[wrap_word(req_word, beat_q)*WORD_W +: WORD_W] = beat_word;
    done       = ((state_q == ST_COMPARE) && lookup_hit) || crit_beat;
  end

  assign cpu_stall   = cpu_req && !done;
  assign cpu_rdata   = (state_q == ST_COMPARE) ? lk_line[req_word*WORD_W +: WORD_W] : mem_rd_data;
  assign hit_wr_en   = (state_q == ST_COMPARE) && lookup_hit && req_we_q;
  assign hit_word    = req_word;
  assign hit_data    = req_wdata_q;
  assign fill_en     = last_beat;
  assign fill_tag    = req_tag;
  assign fill_line   = fill_next;
  assign fill_dirty  = req_we_q;
  assign vb_load     = (state_q == ST_EVICT_COPY);
  assign drain_go    = vb_full && (state_q != ST_EVICT_COPY) && !refilling;
  assign mem_rd_req  = refilling && !rd_issued_q;
  assign mem_rd_addr = word_addr(req_tag, lk_idx, req_word);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (cpu_req) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (lookup_hit)              state_d = ST_IDLE;
        else if (vb_full)            state_d = ST_WRITEBACK;
        else if (lk_valid && lk_dirty) state_d = ST_EVICT_COPY;
        else                         state_d = ST_REFILL;
      end
      ST_WRITEBACK:  if (!vb_full) state_d = ST_COMPARE;
      ST_EVICT_COPY: state_d = ST_REFILL;
      ST_REFILL:     if (last_beat) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
      beat_q      <= '0;
      fill_q      <= '0;
      rd_issued_q <= 1'b0;
      served_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req) begin
        req_addr_q  <= cpu_addr;
        req_we_q    <= cpu_we;
        req_wdata_q <= cpu_wdata;
      end
      if (mem_rd_req) rd_issued_q <= 1'b1;
      if (refilling && mem_rd_valid) begin
        beat_q <= beat_q + 1'b1;
        fill_q <= fill_next;
      end
      if (crit_beat) served_q <= 1'b1;
      if (last_beat) begin
        rd_issued_q <= 1'b0;
        served_q    <= 1'b0;
        beat_q      <= '0;
      end
    end
  end

  // R7
  rd_beat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> refilling && rd_issued_q);

  // R7
  early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> served_q);

  // R10
  rd_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && vb_full |-> $past(state_q) == ST_EVICT_COPY);

  // R2
  aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> cpu_addr[BYTE_W-1:0] == '0);
endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache
  import cwb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_wr_ready
);
  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic [LINE_W-1:0] lk_line;
  logic              hit_wr_en;
  logic [WSEL_W-1:0] hit_word;
  logic [WORD_W-1:0] hit_data;
  logic              fill_en, fill_dirty;
  logic [TAG_W-1:0]  fill_tag;
  logic [LINE_W-1:0] fill_line;
  logic              vb_full, vb_load, drain_go;
  logic              refilling;

  cwb_ctrl u_ctrl (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_stall, .cpu_rdata,
    .lk_idx, .lk_valid, .lk_dirty, .lk_tag, .lk_line,
    .hit_wr_en, .hit_word, .hit_data,
    .fill_en, .fill_tag, .fill_line, .fill_dirty,
    .vb_full, .vb_load, .drain_go,
    .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data, .refilling
  );

  cwb_line_store u_store (
    .clk, .rst_n, .idx(lk_idx),
    .rd_valid(lk_valid), .rd_dirty(lk_dirty), .rd_tag(lk_tag), .rd_line(lk_line),
    .hit_wr_en, .hit_word, .hit_data,
    .fill_en, .fill_tag, .fill_line, .fill_dirty
  );

  cwb_victim_buf u_vbuf (
    .clk, .rst_n, .load_en(vb_load), .load_tag(lk_tag), .load_idx(lk_idx), .load_line(lk_line),
    .drain_go, .full(vb_full),
    .mem_wr_valid, .mem_wr_addr, .mem_wr_data, .mem_wr_ready
  );

  // R6
  rd_before_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refilling |-> !mem_wr_valid);
endmodule

// File: tb/wb_dm_cache_bench.sv
module wb_dm_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_stall;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_valid;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        mem_wr_ready = 1'b0;

  always #4 clk = ~clk;

  wb_dm_cache u_wb_dm_cache (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_stall, .cpu_rdata,
    .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
    .mem_wr_valid, .mem_wr_addr, .mem_wr_data, .mem_wr_ready
  );

  int n_chk = 0, n_err = 0;
  int rd_cnt = 0, burst_beats = 0, wb_total = 0, wb_beat = 0;
  int wb_order_err = 0, overlap_err = 0, gate_err = 0;
  bit rd_busy = 1'b0;
  logic [31:0] last_rd_addr = '0, wb_block = '0;
  logic [31:0] mem  [0:16383];
  logic [31:0] gold [0:16383];

  // {we, exp_hit, nowait, exp_wb_beats[2:0], addr[31:0], wdata[31:0]}
  localparam logic [69:0] VEC [0:13] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_0048, 32'h0},          // R1 cold miss
    {1'b0, 1'b1, 1'b0, 3'd0, 32'h0000_004C, 32'h0},          // R3 read hit
    {1'b1, 1'b1, 1'b0, 3'd0, 32'h0000_0044, 32'h1111_0001},  // R4 write hit
    {1'b0, 1'b1, 1'b0, 3'd0, 32'h0000_0044, 32'h0},          // R4 readback
    {1'b0, 1'b0, 1'b1, 3'd0, 32'h0000_0448, 32'h0},          // R6 dirty miss
    {1'b0, 1'b0, 1'b0, 3'd4, 32'h0000_0044, 32'h0},          // R10 re-fetch victim
    {1'b1, 1'b0, 1'b0, 3'd0, 32'h0000_008C, 32'h2222_0003},  // R8 write miss
    {1'b0, 1'b1, 1'b0, 3'd0, 32'h0000_008C, 32'h0},          // R8 merged hit
    {1'b0, 1'b0, 1'b0, 3'd4, 32'h0000_0880, 32'h0},          // R8 evict dirty
    {1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_008C, 32'h0},          // R5 clean miss
    {1'b1, 1'b0, 1'b0, 3'd0, 32'h0000_03F0, 32'h3333_0000},  // R8 last line
    {1'b0, 1'b0, 1'b0, 3'd4, 32'h0000_07F0, 32'h0},          // R6 evict
    {1'b0, 1'b0, 1'b0, 3'd0, 32'h0000_03F0, 32'h0},          // R5 clean miss
    {1'b0, 1'b1, 1'b0, 3'd0, 32'h0000_03FC, 32'h0}           // R3 hit
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // memory read responder: wrap order from the critical word
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        if (mem_wr_valid) gate_err++;
        rd_cnt++;
        burst_beats = 0;
        rd_busy = 1'b1;
        last_rd_addr = mem_rd_addr;
        for (int b = 0; b < 4; b++) begin
          @(posedge clk); #2;
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem[{mem_rd_addr[15:4], 2'(mem_rd_addr[3:2] + b[1:0])}];
          burst_beats++;
        end
        @(posedge clk); #2;
        mem_rd_valid = 1'b0;
        rd_busy = 1'b0;
      end
    end
  end

  // write channel: ready toggles, beats checked for order
  initial begin
    forever begin
      @(posedge clk); #2;
      mem_wr_ready = ~mem_wr_ready;
    end
  end

  always @(negedge clk) begin
    if (mem_wr_valid && rd_busy) overlap_err++;
    if (mem_wr_valid && mem_wr_ready) begin
      if (wb_beat == 0) wb_block = {mem_wr_addr[31:4], 4'h0};
      if (mem_wr_addr != (wb_block | (wb_beat << 2))) wb_order_err++;
      mem[mem_wr_addr[15:2]] = mem_wr_data;
      wb_beat = (wb_beat + 1) % 4;
      wb_total++;
    end
  end

  task automatic do_op(input logic we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rdata, output int lat, output int rd_d, output int beats);
    int rd0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    rd0 = rd_cnt; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (cpu_stall && lat < 1000);
    rdata = cpu_rdata;
    beats = burst_beats;
    cpu_req = 1'b0; cpu_we = 1'b0;
    #1;
    rd_d = rd_cnt - rd0;
  endtask

  task automatic reset_and_check();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!cpu_stall && !mem_rd_req && !mem_wr_valid, "R11 idle outputs after reset",
        {29'b0, cpu_stall, mem_rd_req, mem_wr_valid}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 16384; i++) begin
      mem[i]  = 32'h5A00_0000 | i;
      gold[i] = 32'h5A00_0000 | i;
    end
    reset_and_check();
    for (int v = 0; v < 14; v++) begin
      logic        we, ehit, nw;
      logic [2:0]  ewb;
      logic [31:0] a, d, rdata;
      int lat, rd_d, beats, wb0;
      {we, ehit, nw, ewb, a, d} = VEC[v];
      wb0 = wb_total;
      do_op(we, a, d, rdata, lat, rd_d, beats);
      if (ehit) begin
        // R3 hit: one cycle, no read burst
        chk(lat == 1 && rd_d == 0, "R3 hit latency/no read", lat, 1);
      end else begin
        // R1 R5 miss: exactly one burst
        chk(rd_d == 1, "R5 miss issues one read", rd_d, 1);
        // R2 refill address is the requested word
        chk(last_rd_addr == {a[31:2], 2'b00}, "R2 refill address", last_rd_addr, a);
        // R7 released on the first beat
        chk(beats == 1, "R7 early restart beat", beats, 1);
      end
      if (!we) chk(rdata == gold[a[15:2]], "R7 R3 read data", rdata, gold[a[15:2]]);
      else     gold[a[15:2]] = d;
      if (!nw) repeat (20) @(negedge clk);
      #1;
      // R6 R8 R9 write-back beats in window (R5: none for clean)
      chk((wb_total - wb0) == int'(ewb), "R6 write-back beat count", wb_total - wb0, ewb);
    end
    // R6: no write beat while a refill is outstanding
    chk(overlap_err == 0, "R6 write during refill", overlap_err, 0);
    // R10: no read request while a victim drains
    chk(gate_err == 0, "R10 read during drain", gate_err, 0);
    // R9: beat order and address
    chk(wb_order_err == 0, "R9 write-back order", wb_order_err, 0);
    // R1: after a second reset a previously cached line misses
    reset_and_check();
    begin
      logic [31:0] rdata;
      int lat, rd_d, beats;
      do_op(1'b0, 32'h0000_0044, 32'h0, rdata, lat, rd_d, beats);
      chk(rd_d == 1 && lat > 1, "R1 miss after reset", rd_d, 1);
      chk(rdata == gold[32'h44 >> 2], "R1 data after reset", rdata, gold[32'h44 >> 2]);
    end
    finish_sim();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end
endmodule